// File: doc/BRIEF.md
# Update-protocol snooping data cache

This block is a direct-mapped, single-word-per-line data cache that serves one processor in a system where several caches share one bus. Coherence is kept by broadcasting updates instead of invalidating. A valid line is Exclusive-clean, Shared-clean or Dirty. Writes to a Shared line go through to memory, and the other holders patch their copies. A wired-OR sharing signal tells the writer whether anyone else still holds the block. A Dirty line is the only kind that needs a write-back when it is displaced.

The processor holds a request (read or write, address, write data) until a one-cycle ready pulse comes back. On the bus side the block issues its own transactions through a master port. Each transaction has a one-cycle address phase. The shared line and the fill data are sampled exactly one cycle later. Through a separate snoop port the block watches the transactions of the other caches. One cycle after a snooped address phase it answers with its share flag, the supplied data, and a flag asking memory to capture the data when a Dirty copy is handed over. Arbitration and main memory are outside the block.

Top module: `upd_snoop_cache`

## Requirements
- R1: A read hit returns the stored word with one ready pulse, issues no bus transaction and leaves the line state as it was.
- R2: A read miss issues a bus read (command 1) to the requested address. When the shared input is low in the cycle after the address phase, the filled line becomes Exclusive-clean and the fill word is returned.
- R3: A read miss answered with the shared input high leaves the line Shared, so a later write to it goes out on the bus.
- R4: A write hit on an Exclusive-clean line updates the cache only and makes the line Dirty. A write hit on a Dirty line updates the cache only.
- R5: A write hit on a Shared line issues a write-through (command 2) carrying the address and new data. The line stays Shared if the shared input is high one cycle after the address phase, and becomes Exclusive-clean otherwise.
- R6: A write miss first performs a bus read. If nobody shares the block, the write data is merged and the line becomes Dirty with no further transaction. If the block is shared, a write-through of the new data follows and the line stays Shared.
- R7: A miss that displaces a Dirty line first issues a write-back (command 3) of the old address and data. The fill read comes two cycles after the write-back address phase. Clean lines are replaced with no write-back.
- R8: A snooped read (command 1) that hits raises the share and supply outputs with the stored word one cycle after its address phase. If the line was Dirty, the memory-capture flag is raised too. Either way the line becomes Shared.
- R9: A snooped write-through (command 2) that hits raises the share output one cycle later without supplying data, and overwrites the stored word.
- R10: A snoop whose tag does not match, or a snooped write-back (command 3), raises no snoop output and leaves the cached word unchanged.
- R11: Ready is a single-cycle pulse that never coincides with a bus address phase. It comes only after every transaction of the request, including a write-back before a fill and a merged write-through.
- R12: Reset clears every line's valid bit and drives ready, the bus request and every snoop output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with ready |
| mst_valid | output | 1 | Own address phase (one cycle) |
| mst_cmd | output | 2 | 1 read, 2 write-through, 3 write-back |
| mst_addr | output | ADDR_W | Own transaction address |
| mst_wdata | output | DATA_W | Own transaction write data |
| mst_rdata | input | DATA_W | Fill word, one cycle after address phase |
| mst_shared | input | 1 | Wired-OR share line from the other caches |
| snp_valid | input | 1 | Address phase of another cache's transaction |
| snp_cmd | input | 2 | Snooped command, same encoding as mst_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_wdata | input | DATA_W | Snooped write data |
| snp_shared_out | output | 1 | This cache holds the snooped block |
| snp_supply | output | 1 | This cache drives snp_rdata |
| snp_flush | output | 1 | Supplied word came from a Dirty line; memory should capture it |
| snp_rdata | output | DATA_W | Word supplied on a snoop read hit |

## Verification
The hardest situation to reach is a miss that lands on a Dirty line whose block other caches also want. The line must first become Dirty through a clean fill followed by a local write. It then has to survive a snooped read, which drops it to Shared, and go back to Exclusive-clean through a write-through answered with the shared line low, before a second local write makes it Dirty again. A different tag at the same index then forces the write-back-then-fill pair. The stimulus walks one index through exactly that chain, steering the shared response for each of its own transactions. At each step it infers the hidden line state from whether the next access produces bus traffic or a flush flag.

// File: rtl/usc_pkg.sv
package usc_pkg;
  typedef enum logic [1:0] {
    LS_EXCL   = 2'd0,
    LS_SHARED = 2'd1,
    LS_DIRTY  = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE  = 2'd0,
    BC_READ  = 2'd1,
    BC_WRTHR = 2'd2,
    BC_WRBK  = 2'd3
  } bus_cmd_e;
endpackage

// File: rtl/usc_line_store.sv
module usc_line_store
  import usc_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  a_idx,
  output logic              a_valid,
  output logic [TAG_W-1:0]  a_tag,
  output line_st_e          a_st,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output logic              b_valid,
  output logic [TAG_W-1:0]  b_tag,
  output line_st_e          b_st,
  output logic [DATA_W-1:0] b_data,
  input  logic              sw_en,
  input  logic              sw_den,
  input  line_st_e          sw_st,
  input  logic [DATA_W-1:0] sw_data,
  input  logic              cw_en,
  input  logic [TAG_W-1:0]  cw_tag,
  input  line_st_e          cw_st,
  input  logic [DATA_W-1:0] cw_data
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  vld;
  logic [TAG_W-1:0]  tag_mem [LINES];
  line_st_e          st_mem  [LINES];
  logic [DATA_W-1:0] dat_mem [LINES];

  assign a_valid = vld[a_idx];
  assign a_tag   = tag_mem[a_idx];
  assign a_st    = st_mem[a_idx];
  assign a_data  = dat_mem[a_idx];
  assign b_valid = vld[b_idx];
  assign b_tag   = tag_mem[b_idx];
  assign b_st    = st_mem[b_idx];
  assign b_data  = dat_mem[b_idx];

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (cw_en) vld[a_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (cw_en) tag_mem[a_idx] <= cw_tag;
  end

  // snoop port first, processor port last: the later write wins on a clash
  always_ff @(posedge clk) begin
    if (sw_en) st_mem[b_idx] <= sw_st;
    if (cw_en) st_mem[a_idx] <= cw_st;
  end

  always_ff @(posedge clk) begin
    if (sw_den) dat_mem[b_idx] <= sw_data;
    if (cw_en)  dat_mem[a_idx] <= cw_data;
  end
endmodule

// File: rtl/usc_snoop.sv
module usc_snoop
  import usc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    snp_valid,
  input  logic [1:0]              snp_cmd,
  input  logic [ADDR_W-1:0]       snp_addr,
  input  logic [DATA_W-1:0]       snp_wdata,
  output logic [IDX_W-1:0]        look_idx,
  input  logic                    look_valid,
  input  logic [ADDR_W-IDX_W-1:0] look_tag,
  input  line_st_e                look_st,
  input  logic [DATA_W-1:0]       look_data,
  output logic                    sw_en,
  output logic                    sw_den,
  output line_st_e                sw_st,
  output logic [DATA_W-1:0]       sw_data,
  output logic                    snp_shared_out,
  output logic                    snp_supply,
  output logic                    snp_flush,
  output logic [DATA_W-1:0]       snp_rdata
);
  bus_cmd_e cmd;
  logic     tag_hit, claim, is_rd, is_wt;

  assign cmd      = bus_cmd_e'(snp_cmd);
  assign look_idx = snp_addr[IDX_W-1:0];
  assign tag_hit  = look_valid && (look_tag == snp_addr[ADDR_W-1:IDX_W]);
  assign is_rd    = (cmd == BC_READ);
  assign is_wt    = (cmd == BC_WRTHR);
  assign claim    = snp_valid && tag_hit && (is_rd || is_wt);

  assign sw_en   = claim;
  assign sw_den  = claim && is_wt;
  assign sw_st   = LS_SHARED;
  assign sw_data = snp_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      snp_shared_out <= 1'b0;
      snp_supply     <= 1'b0;
      snp_flush      <= 1'b0;
      snp_rdata      <= '0;
    end else begin
      snp_shared_out <= claim;
      snp_supply     <= claim && is_rd;
      snp_flush      <= claim && is_rd && (look_st == LS_DIRTY);
      if (claim && is_rd) snp_rdata <= look_data;
    end
  end

  AST_FLUSH_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (rst)
    snp_flush |-> snp_supply); // R8
  AST_SUPPLY_IMPLIES_SHARE: assert property (@(posedge clk) disable iff (rst)
    snp_supply |-> snp_shared_out); // R8
  AST_SHARE_ONLY_AFTER_SNOOP: assert property (@(posedge clk) disable iff (rst)
    !$past(snp_valid) |-> !snp_shared_out); // R10
endmodule

// File: rtl/usc_ctrl.sv
module usc_ctrl
  import usc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic                    cpu_ready,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    mst_valid,
  output logic [1:0]              mst_cmd,
  output logic [ADDR_W-1:0]       mst_addr,
  output logic [DATA_W-1:0]       mst_wdata,
  input  logic [DATA_W-1:0]       mst_rdata,
  input  logic                    mst_shared,
  output logic [IDX_W-1:0]        look_idx,
  input  logic                    look_valid,
  input  logic [ADDR_W-IDX_W-1:0] look_tag,
  input  line_st_e                look_st,
  input  logic [DATA_W-1:0]       look_data,
  output logic                    cw_en,
  output logic [ADDR_W-IDX_W-1:0] cw_tag,
  output line_st_e                cw_st,
  output logic [DATA_W-1:0]       cw_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {C_IDLE, C_ADDR, C_RESP} ctrl_st_e;

  ctrl_st_e         st;
  bus_cmd_e         op;
  logic [TAG_W-1:0] req_tag;
  logic             go, hit;

  assign look_idx = cpu_addr[IDX_W-1:0];
  assign req_tag  = cpu_addr[ADDR_W-1:IDX_W];
  assign go       = cpu_req && !cpu_ready;
  assign hit      = look_valid && (look_tag == req_tag);

  // line updates happen in the same edge as the decision
  always_comb begin
    cw_en   = 1'b0;
    cw_tag  = req_tag;
    cw_st   = look_st;
    cw_data = look_data;
    unique case (st)
      C_IDLE: begin
        if (go && hit && cpu_we && look_st != LS_SHARED) begin
          cw_en   = 1'b1;
          cw_st   = LS_DIRTY;
          cw_data = cpu_wdata;
        end
      end
      C_RESP: begin
        unique case (op)
          BC_READ: begin
            cw_en = 1'b1;
            if (mst_shared) begin
              cw_st   = LS_SHARED;
              cw_data = mst_rdata;
            end else if (cpu_we) begin
              cw_st   = LS_DIRTY;
              cw_data = cpu_wdata;
            end else begin
              cw_st   = LS_EXCL;
              cw_data = mst_rdata;
            end
          end
          BC_WRTHR: begin
            cw_en   = 1'b1;
            cw_st   = mst_shared ? LS_SHARED : LS_EXCL;
            cw_data = cpu_wdata;
          end
          BC_WRBK: begin
            cw_en  = 1'b1;
            cw_tag = look_tag;
            cw_st  = LS_EXCL;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= C_IDLE;
      op        <= BC_NONE;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
      mst_valid <= 1'b0;
      mst_cmd   <= BC_NONE;
      mst_addr  <= '0;
      mst_wdata <= '0;
    end else begin
      cpu_ready <= 1'b0;
      mst_valid <= 1'b0;
      unique case (st)
        C_IDLE: begin
          if (go) begin
            if (hit) begin
              if (!cpu_we) begin
                cpu_rdata <= look_data;
                cpu_ready <= 1'b1;
              end else if (look_st == LS_SHARED) begin
                mst_valid <= 1'b1;
                mst_cmd   <= BC_WRTHR;
                mst_addr  <= cpu_addr;
                mst_wdata <= cpu_wdata;
                op        <= BC_WRTHR;
                st        <= C_ADDR;
              end else begin
                cpu_ready <= 1'b1;
              end
            end else if (look_valid && look_st == LS_DIRTY) begin
              mst_valid <= 1'b1;
              mst_cmd   <= BC_WRBK;
              mst_addr  <= {look_tag, look_idx};
              mst_wdata <= look_data;
              op        <= BC_WRBK;
              st        <= C_ADDR;
            end else begin
              mst_valid <= 1'b1;
              mst_cmd   <= BC_READ;
              mst_addr  <= cpu_addr;
              mst_wdata <= '0;
              op        <= BC_READ;
              st        <= C_ADDR;
            end
          end
        end
        C_ADDR: st <= C_RESP;
        C_RESP: begin
          unique case (op)
            BC_WRBK: begin
              mst_valid <= 1'b1;
              mst_cmd   <= BC_READ;
              mst_addr  <= cpu_addr;
              mst_wdata <= '0;
              op        <= BC_READ;
              st        <= C_ADDR;
            end
            BC_READ: begin
              if (cpu_we && mst_shared) begin
                mst_valid <= 1'b1;
                mst_cmd   <= BC_WRTHR;
                mst_addr  <= cpu_addr;
                mst_wdata <= cpu_wdata;
                op        <= BC_WRTHR;
                st        <= C_ADDR;
              end else begin
                if (!cpu_we) cpu_rdata <= mst_rdata;
                cpu_ready <= 1'b1;
                st        <= C_IDLE;
              end
            end
            default: begin
              cpu_ready <= 1'b1;
              st        <= C_IDLE;
            end
          endcase
        end
        default: st <= C_IDLE;
      endcase
    end
  end

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready); // R11
  AST_READY_NOT_WITH_BUS: assert property (@(posedge clk) disable iff (rst)
    mst_valid |-> !cpu_ready); // R11
  AST_ADDR_PHASE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    mst_valid |=> !mst_valid); // R5
  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (rst)
    (mst_valid && mst_cmd == BC_WRBK) |-> ##2 (mst_valid && mst_cmd == BC_READ)); // R7
  AST_RDHIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st == C_IDLE && go && hit && !cpu_we) |=> (cpu_ready && !mst_valid)); // R1
endmodule

// File: rtl/upd_snoop_cache.sv
module upd_snoop_cache
  import usc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mst_valid,
  output logic [1:0]        mst_cmd,
  output logic [ADDR_W-1:0] mst_addr,
  output logic [DATA_W-1:0] mst_wdata,
  input  logic [DATA_W-1:0] mst_rdata,
  input  logic              mst_shared,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [DATA_W-1:0] snp_wdata,
  output logic              snp_shared_out,
  output logic              snp_supply,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_rdata
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  a_idx, b_idx;
  logic              a_valid, b_valid;
  logic [TAG_W-1:0]  a_tag, b_tag;
  line_st_e          a_st, b_st;
  logic [DATA_W-1:0] a_data, b_data;
  logic              sw_en, sw_den, cw_en;
  line_st_e          sw_st, cw_st;
  logic [DATA_W-1:0] sw_data, cw_data;
  logic [TAG_W-1:0]  cw_tag;

  usc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst(rst),
    .a_idx(a_idx), .a_valid(a_valid), .a_tag(a_tag), .a_st(a_st), .a_data(a_data),
    .b_idx(b_idx), .b_valid(b_valid), .b_tag(b_tag), .b_st(b_st), .b_data(b_data),
    .sw_en(sw_en), .sw_den(sw_den), .sw_st(sw_st), .sw_data(sw_data),
    .cw_en(cw_en), .cw_tag(cw_tag), .cw_st(cw_st), .cw_data(cw_data)
  );

  usc_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mst_valid(mst_valid), .mst_cmd(mst_cmd), .mst_addr(mst_addr), .mst_wdata(mst_wdata),
    .mst_rdata(mst_rdata), .mst_shared(mst_shared),
    .look_idx(a_idx), .look_valid(a_valid), .look_tag(a_tag), .look_st(a_st),
    .look_data(a_data),
    .cw_en(cw_en), .cw_tag(cw_tag), .cw_st(cw_st), .cw_data(cw_data)
  );

  usc_snoop #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst(rst),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_wdata(snp_wdata),
    .look_idx(b_idx), .look_valid(b_valid), .look_tag(b_tag), .look_st(b_st),
    .look_data(b_data),
    .sw_en(sw_en), .sw_den(sw_den), .sw_st(sw_st), .sw_data(sw_data),
    .snp_shared_out(snp_shared_out), .snp_supply(snp_supply), .snp_flush(snp_flush),
    .snp_rdata(snp_rdata)
  );
endmodule

// File: tb/upd_snoop_cache_tb.sv
module upd_snoop_cache_tb;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst;
  logic cpu_req, cpu_we, cpu_ready;
  logic [AW-1:0] cpu_addr, mst_addr, snp_addr;
  logic [DW-1:0] cpu_wdata, cpu_rdata, mst_wdata, mst_rdata, snp_wdata, snp_rdata;
  logic mst_valid, mst_shared, snp_valid, snp_shared_out, snp_supply, snp_flush;
  logic [1:0] mst_cmd, snp_cmd;

  upd_snoop_cache #(.ADDR_W(AW), .IDX_W(4), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mst_valid(mst_valid), .mst_cmd(mst_cmd), .mst_addr(mst_addr), .mst_wdata(mst_wdata),
    .mst_rdata(mst_rdata), .mst_shared(mst_shared),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_wdata(snp_wdata),
    .snp_shared_out(snp_shared_out), .snp_supply(snp_supply), .snp_flush(snp_flush),
    .snp_rdata(snp_rdata)
  );

  int n_chk = 0;
  int n_err = 0;

  logic [1:0]    tx_cmd  [4];
  logic [AW-1:0] tx_addr [4];
  logic [DW-1:0] tx_dat  [4];
  int            n_tx;
  logic [DW-1:0] rd;
  logic          s_sh, s_sup, s_fl;
  logic [DW-1:0] s_dat;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one processor request; sh0/sh1 answer the first/second bus transaction
  task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic sh0, input logic sh1, input logic [DW-1:0] fill);
    logic done;
    done = 1'b0;
    n_tx = 0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (mst_valid) begin
        if (n_tx < 4) begin
          tx_cmd[n_tx] = mst_cmd; tx_addr[n_tx] = mst_addr; tx_dat[n_tx] = mst_wdata;
        end
        mst_shared = (n_tx == 0) ? sh0 : sh1;
        mst_rdata  = fill;
        n_tx++;
      end
      if (cpu_ready) begin
        rd = cpu_rdata;
        done = 1'b1;
        break;
      end
    end
    chk("R11 request completes", {31'b0, done}, 32'd1);
    cpu_req = 1'b0;
    @(negedge clk);
    chk("R11 ready single pulse", {31'b0, cpu_ready}, 32'd0);
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a; snp_wdata = d;
    @(negedge clk);
    snp_valid = 1'b0;
    s_sh = snp_shared_out; s_sup = snp_supply; s_fl = snp_flush; s_dat = snp_rdata;
  endtask

  task automatic t_reset;
    chk("R12 ready low", {31'b0, cpu_ready}, 32'd0);
    chk("R12 bus idle", {31'b0, mst_valid}, 32'd0);
    chk("R12 share low", {31'b0, snp_shared_out}, 32'd0);
    snoop(2'd1, 16'h0011, 0);
    chk("R12 empty cache claims nothing", {31'b0, s_sh}, 32'd0);
  endtask

  task automatic t_exclusive_path;
    cpu_op(1'b0, 16'h0011, 0, 1'b0, 1'b0, 32'hA1A1_0001);
    chk("R2 one bus txn", n_tx, 1);
    chk("R2 read cmd", tx_cmd[0], 1);
    chk("R2 read addr", tx_addr[0], 32'h0011);
    chk("R2 fill data", rd, 32'hA1A1_0001);
    cpu_op(1'b0, 16'h0011, 0, 1'b0, 1'b0, 0);
    chk("R1 hit no bus", n_tx, 0);
    chk("R1 hit data", rd, 32'hA1A1_0001);
    cpu_op(1'b1, 16'h0011, 32'hB2B2_0002, 1'b0, 1'b0, 0);
    chk("R4 exclusive write no bus", n_tx, 0);
    cpu_op(1'b1, 16'h0011, 32'hC3C3_0003, 1'b0, 1'b0, 0);
    chk("R4 dirty write no bus", n_tx, 0);
    snoop(2'd1, 16'h0011, 0);
    chk("R8 share", {31'b0, s_sh}, 32'd1);
    chk("R8 supply", {31'b0, s_sup}, 32'd1);
    chk("R8 flush from dirty", {31'b0, s_fl}, 32'd1);
    chk("R8 supplied word", s_dat, 32'hC3C3_0003);
    cpu_op(1'b1, 16'h0011, 32'hD4D4_0004, 1'b0, 1'b0, 0);
    chk("R8 now shared so write-through", n_tx, 1);
    chk("R5 write-through cmd", tx_cmd[0], 2);
    chk("R5 write-through addr", tx_addr[0], 32'h0011);
    chk("R5 write-through data", tx_dat[0], 32'hD4D4_0004);
    cpu_op(1'b1, 16'h0011, 32'hE5E5_0005, 1'b0, 1'b0, 0);
    chk("R5 unshared writer went exclusive", n_tx, 0);
  endtask

  task automatic t_shared_path;
    cpu_op(1'b0, 16'h0025, 0, 1'b1, 1'b0, 32'hF6F6_0006);
    chk("R3 read cmd", tx_cmd[0], 1);
    chk("R3 fill data", rd, 32'hF6F6_0006);
    snoop(2'd1, 16'h0025, 0);
    chk("R8 clean holder no flush", {31'b0, s_fl}, 32'd0);
    chk("R8 clean holder supplies", s_dat, 32'hF6F6_0006);
    cpu_op(1'b1, 16'h0025, 32'h0000_0077, 1'b1, 1'b0, 0);
    chk("R3 shared line writes through", n_tx, 1);
    chk("R3 write-through data", tx_dat[0], 32'h0000_0077);
    cpu_op(1'b1, 16'h0025, 32'h0000_0088, 1'b1, 1'b0, 0);
    chk("R5 still shared", n_tx, 1);
    chk("R5 cmd", tx_cmd[0], 2);
  endtask

  task automatic t_snoop_update;
    snoop(2'd2, 16'h0025, 32'h0000_0099);
    chk("R9 share on update", {31'b0, s_sh}, 32'd1);
    chk("R9 no supply on update", {31'b0, s_sup}, 32'd0);
    cpu_op(1'b0, 16'h0025, 0, 1'b0, 1'b0, 0);
    chk("R9 updated copy hit", n_tx, 0);
    chk("R9 updated word", rd, 32'h0000_0099);
  endtask

  task automatic t_snoop_ignore;
    snoop(2'd1, 16'h0035, 0);
    chk("R10 tag mismatch share", {31'b0, s_sh}, 32'd0);
    chk("R10 tag mismatch supply", {31'b0, s_sup}, 32'd0);
    snoop(2'd3, 16'h0025, 32'hDEAD_BEEF);
    chk("R10 write-back snoop share", {31'b0, s_sh}, 32'd0);
    cpu_op(1'b0, 16'h0025, 0, 1'b0, 1'b0, 0);
    chk("R10 word unchanged", rd, 32'h0000_0099);
  endtask

  task automatic t_write_miss;
    cpu_op(1'b1, 16'h0047, 32'h0000_00AB, 1'b0, 1'b0, 32'h1234_5678);
    chk("R6 unshared miss one txn", n_tx, 1);
    chk("R6 read first", tx_cmd[0], 1);
    snoop(2'd1, 16'h0047, 0);
    chk("R6 ends dirty", {31'b0, s_fl}, 32'd1);
    chk("R6 merged word", s_dat, 32'h0000_00AB);
    cpu_op(1'b1, 16'h0058, 32'h0000_00CD, 1'b1, 1'b1, 32'h5555_5555);
    chk("R11 ready after both txns", n_tx, 2);
    chk("R6 read then", tx_cmd[0], 1);
    chk("R6 write-through", tx_cmd[1], 2);
    chk("R6 write-through addr", tx_addr[1], 32'h0058);
    chk("R6 write-through data", tx_dat[1], 32'h0000_00CD);
    cpu_op(1'b1, 16'h0058, 32'h0000_00EF, 1'b1, 1'b0, 0);
    chk("R6 shared result writes through", n_tx, 1);
  endtask

  task automatic t_evict;
    cpu_op(1'b0, 16'h0101, 0, 1'b0, 1'b0, 32'h0F0F_0F0F);
    chk("R7 two txns", n_tx, 2);
    chk("R7 write-back first", tx_cmd[0], 3);
    chk("R7 victim addr", tx_addr[0], 32'h0011);
    chk("R7 victim data", tx_dat[0], 32'hE5E5_0005);
    chk("R7 fill next", tx_cmd[1], 1);
    chk("R7 fill addr", tx_addr[1], 32'h0101);
    chk("R7 fill data", rd, 32'h0F0F_0F0F);
    cpu_op(1'b0, 16'h0125, 0, 1'b0, 1'b0, 32'h2525_2525);
    chk("R7 clean victim no write-back", n_tx, 1);
    chk("R7 clean replace read", tx_cmd[0], 1);
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1;
    cpu_req = 0; cpu_we = 0; cpu_addr = 0; cpu_wdata = 0;
    mst_rdata = 0; mst_shared = 0;
    snp_valid = 0; snp_cmd = 0; snp_addr = 0; snp_wdata = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_exclusive_path;
    t_shared_path;
    t_snoop_update;
    t_snoop_ignore;
    t_write_miss;
    t_evict;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule